// File: doc/BRIEF.md
# Header Packet Framing Receiver

This link-layer receive block watches a stream of decoded symbols, finds the four-symbol header-start framing, and collects the fixed-length header payload that follows. For every packet it recognises, it asks the link to send either an acknowledge or a bad-packet reply. Each incoming symbol carries an 8-bit value, a control-character flag and a decode-error flag. The framing is tolerant: a single damaged framing symbol in any position still lets the packet through.

Damage inside the payload never takes the link out of its active state. That includes a framing control code that shows up in the middle of the body. Such damage only turns the reply into a bad-packet request, so the sender's retransmission can be received and acknowledged. A recovery request is raised only when the framing itself cannot be recognised. The block checks nothing until the link-state input reports the active state.

The symbol input is a valid/ready stream. The block never applies back-pressure, so `sym_ready` is held high outside reset. A symbol transfers on every rising clock edge where `sym_valid` is high. Cycles with `sym_valid` low carry no symbol and advance nothing.

Top module: `hp_frame_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `ack_req`, `lbad_req` and `recov_req` are low. Outside reset `sym_ready` is high.
- R2: The framing is four control symbols (`sym_ctrl`=1, `sym_err`=0): value 0x5C in the first three positions and 0xF7 in the fourth. It is followed by 16 data symbols (`sym_ctrl`=0, `sym_err`=0), with `crc_ok` high when the 16th is transferred. Such a packet produces an `ack_req` pulse.
- R3: The framing is still accepted when exactly one of its four symbols is damaged. Damaged means it carries a decode error, has the wrong value, or has the wrong control flag. This holds for each of the four positions.
- R4: An attempt starts when, while hunting, a control symbol of value 0x5C or 0xF7 arrives, or a symbol with `sym_err` set arrives. If the attempt's 4th symbol does not complete a framing with at least three matching positions, `recov_req` pulses for one cycle in the cycle after that symbol, and no reply is issued.
- R5: A payload symbol with `sym_ctrl`=1 or `sym_err`=1 produces `lbad_req` instead of `ack_req`. This includes the framing codes 0x5C and 0xF7, and every position from the first to the last. `recov_req` is never raised for payload content.
- R6: If `crc_ok` is low in the cycle where the 16th payload symbol is transferred, the reply is `lbad_req`.
- R7: `ack_req` and `lbad_req` are one-cycle pulses and are never high together. A reply is high in the cycle after the 16th payload symbol is transferred. Cycles with `sym_valid` low inside the payload are not counted.
- R8: After a reply the block hunts again, so a retransmitted clean packet that follows a rejected one is acknowledged.
- R9: While `link_u0` is low, symbols are ignored and no output pulses. A packet in progress when `link_u0` falls is discarded with no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| link_u0 | input | 1 | High while the link is in its active state |
| sym_valid | input | 1 | A symbol is offered this cycle |
| sym_ready | output | 1 | Block accepts a symbol (always high outside reset) |
| sym_data | input | 8 | Decoded symbol value |
| sym_ctrl | input | 1 | Symbol is a control character |
| sym_err | input | 1 | Symbol had a decode error |
| crc_ok | input | 1 | Header CRC check result, sampled with the last payload symbol |
| ack_req | output | 1 | One-cycle request to send an acknowledge |
| lbad_req | output | 1 | One-cycle request to send a bad-packet reply |
| recov_req | output | 1 | One-cycle request to leave the active state for recovery |

## Verification
The bench damages the framing in each of the four positions. One case turns the first framing symbol into an ordinary data character, which a detector fixed to the first control code would misalign on and answer with a false recovery. It places bad payload symbols at the first, middle and last positions, including a framing code mid-body. A design that restarts framing on such a code would raise recovery instead of a bad-packet reply. Idle gaps inside the payload catch a counter that advances on invalid cycles and replies too early. Dropping the link mid-packet catches a design that keeps its partial count and so misreads the next clean packet.

// File: rtl/hp_frame_pkg.sv
package hp_frame_pkg;
  localparam int SYM_W     = 8;
  localparam int FRAME_LEN = 4;
  localparam logic [SYM_W-1:0] CODE_START = 8'h5C;
  localparam logic [SYM_W-1:0] CODE_END   = 8'hF7;

  typedef struct packed {
    logic             ctrl;
    logic             err;
    logic [SYM_W-1:0] data;
  } sym_t;

  typedef enum logic {ST_HUNT, ST_BODY} rx_state_e;

  // expected framing symbol at a given position
  function automatic logic frame_pos_ok(sym_t s, int pos);
    logic [SYM_W-1:0] want;
    want = (pos == FRAME_LEN-1) ? CODE_END : CODE_START;
    return s.ctrl && !s.err && (s.data == want);
  endfunction

  // symbol that opens a framing attempt while hunting
  function automatic logic opens_attempt(sym_t s);
    return s.err || (s.ctrl && ((s.data == CODE_START) || (s.data == CODE_END)));
  endfunction
endpackage

// File: rtl/hp_frame_detect.sv
module hp_frame_detect
  import hp_frame_pkg::*;
#(
  parameter int MIN_MATCH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  sym_t cur,
  output logic hit,
  output logic miss
);
  localparam int HIST  = FRAME_LEN - 1;
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  sym_t               win [HIST];
  logic [FRAME_LEN-1:0] pos_ok;
  logic [CNT_W-1:0]   att_cnt;
  logic               enough;

  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_pos
    if (g == FRAME_LEN-1) begin : g_cur
      assign pos_ok[g] = frame_pos_ok(cur, g);
    end else begin : g_hist
      assign pos_ok[g] = frame_pos_ok(win[g], g);
    end
  end

  assign enough = ($countones(pos_ok) >= MIN_MATCH);
  assign hit    = en && enough;
  assign miss   = en && !enough && (att_cnt == CNT_W'(FRAME_LEN-1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || hit || miss) begin
      for (int i = 0; i < HIST; i++) win[i] <= '0;
      att_cnt <= '0;
    end else if (en) begin
      for (int i = 0; i < HIST-1; i++) win[i] <= win[i+1];
      win[HIST-1] <= cur;
      if (att_cnt != '0)          att_cnt <= att_cnt + 1'b1;
      else if (opens_attempt(cur)) att_cnt <= CNT_W'(1);
    end
  end

  // R3: a clean framing (all four positions right) is always accepted
  a_r3_clean_frame_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (&pos_ok)) |-> hit);
  // R4: a miss never comes on the very next symbol after another one
  a_r4_miss_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !miss);
endmodule

// File: rtl/hp_body_check.sv
module hp_body_check
  import hp_frame_pkg::*;
#(
  parameter int PAYLOAD_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic take,
  input  sym_t cur,
  input  logic crc_ok,
  output logic last,
  output logic ack_o,
  output logic lbad_o
);
  localparam int CNT_W = $clog2(PAYLOAD_LEN);

  logic [CNT_W-1:0] cnt;
  logic             bad;
  logic             sym_good;
  logic             pass;

  assign sym_good = !cur.ctrl && !cur.err;
  assign last     = take && (cnt == CNT_W'(PAYLOAD_LEN-1));
  assign pass     = !bad && sym_good && crc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      cnt <= '0;
      bad <= 1'b0;
    end else if (take) begin
      if (last) begin
        cnt <= '0;
        bad <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        bad <= bad | !sym_good;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_o  <= 1'b0;
      lbad_o <= 1'b0;
    end else begin
      ack_o  <= last && !abort && pass;
      lbad_o <= last && !abort && !pass;
    end
  end

  // R7: replies exclusive and one cycle wide
  a_r7_reply_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && lbad_o));
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  a_r7_lbad_single: assert property (@(posedge clk) disable iff (!rst_n)
    lbad_o |=> !lbad_o);
  // R6: a failed CRC on the last symbol never yields an acknowledge
  a_r6_crc_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !crc_ok) |=> !ack_o);
endmodule

// File: rtl/hp_frame_rx.sv
module hp_frame_rx
  import hp_frame_pkg::*;
#(
  parameter int PAYLOAD_LEN = 16,
  parameter int MIN_MATCH   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_u0,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_data,
  input  logic             sym_ctrl,
  input  logic             sym_err,
  input  logic             crc_ok,
  output logic             ack_req,
  output logic             lbad_req,
  output logic             recov_req
);
  rx_state_e state;
  sym_t      cur;
  logic      fire, hunt_en, body_take;
  logic      hit, miss, body_last;

  assign sym_ready = rst_n;
  assign fire      = sym_valid && sym_ready && link_u0;
  assign cur       = '{ctrl: sym_ctrl, err: sym_err, data: sym_data};
  assign hunt_en   = fire && (state == ST_HUNT);
  assign body_take = fire && (state == ST_BODY);

  hp_frame_detect #(.MIN_MATCH(MIN_MATCH)) u_detect (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!link_u0),
    .en   (hunt_en),
    .cur  (cur),
    .hit  (hit),
    .miss (miss)
  );

  hp_body_check #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_body (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (!link_u0),
    .take  (body_take),
    .cur   (cur),
    .crc_ok(crc_ok),
    .last  (body_last),
    .ack_o (ack_req),
    .lbad_o(lbad_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !link_u0)  state <= ST_HUNT;
    else if (hit)            state <= ST_BODY;
    else if (body_last)      state <= ST_HUNT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) recov_req <= 1'b0;
    else        recov_req <= miss && link_u0;
  end

  // R5: no recovery request can follow a body cycle
  a_r5_no_recov_from_body: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BODY) |=> !recov_req);
  // R2: a reply only follows a cycle spent collecting the body
  a_r2_reply_after_body: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req || lbad_req) |-> $past(state == ST_BODY));
  // R9: a link that is not active silences every request
  a_r9_link_down_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !link_u0 |=> !(ack_req || lbad_req || recov_req));
  // R4: recovery and a reply never coincide
  a_r4_recov_alone: assert property (@(posedge clk) disable iff (!rst_n)
    recov_req |-> !(ack_req || lbad_req));
  // R1: ready stays high outside reset
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready);
endmodule

// File: tb/hp_frame_rx_tb.sv
module hp_frame_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN       = 16;
  localparam logic [7:0] C_START = 8'h5C;
  localparam logic [7:0] C_END   = 8'hF7;

  typedef struct packed {
    logic [2:0] fa;   // damaged framing position (4 = none)
    logic [2:0] fb;   // second damaged position (4 = none)
    logic       fk;   // 0: decode error, 1: value kept but control flag cleared
    logic [4:0] pi;   // bad payload index (16 = none)
    logic [1:0] pk;   // 0: control 0xAA, 1: decode error, 2: control end code
    logic       crc;
    logic [1:0] ex;   // 0 ack, 1 lbad, 2 recovery
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 3'd4, 1'b0, 5'd16, 2'd0, 1'b1, 2'd0},
    '{3'd0, 3'd4, 1'b0, 5'd16, 2'd0, 1'b1, 2'd0},
    '{3'd1, 3'd4, 1'b1, 5'd16, 2'd0, 1'b1, 2'd0},
    '{3'd2, 3'd4, 1'b0, 5'd16, 2'd0, 1'b1, 2'd0},
    '{3'd3, 3'd4, 1'b1, 5'd16, 2'd0, 1'b1, 2'd0},
    '{3'd0, 3'd4, 1'b1, 5'd16, 2'd0, 1'b1, 2'd0},
    '{3'd0, 3'd1, 1'b0, 5'd16, 2'd0, 1'b1, 2'd2},
    '{3'd1, 3'd2, 1'b1, 5'd16, 2'd0, 1'b1, 2'd2},
    '{3'd4, 3'd4, 1'b0, 5'd5,  2'd0, 1'b1, 2'd1},
    '{3'd4, 3'd4, 1'b0, 5'd0,  2'd1, 1'b1, 2'd1},
    '{3'd4, 3'd4, 1'b0, 5'd8,  2'd2, 1'b1, 2'd1},
    '{3'd4, 3'd4, 1'b0, 5'd16, 2'd0, 1'b0, 2'd1},
    '{3'd4, 3'd4, 1'b0, 5'd15, 2'd0, 1'b1, 2'd1}
  };
  localparam vec_t CLEAN = '{3'd4, 3'd4, 1'b0, 5'd16, 2'd0, 1'b1, 2'd0};

  logic clk = 1'b0, rst_n = 1'b0, link_u0 = 1'b1;
  logic sym_valid = 1'b0, sym_ctrl = 1'b0, sym_err = 1'b0, crc_ok = 1'b1;
  logic [7:0] sym_data = '0;
  logic sym_ready, ack_req, lbad_req, recov_req;
  int total = 0, bad = 0;
  int n_ack = 0, n_lbad = 0, n_rec = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .link_u0(link_u0), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .sym_data(sym_data), .sym_ctrl(sym_ctrl),
    .sym_err(sym_err), .crc_ok(crc_ok), .ack_req(ack_req),
    .lbad_req(lbad_req), .recov_req(recov_req)
  );

  always @(negedge clk) if (rst_n) begin
    n_ack  += int'(ack_req);
    n_lbad += int'(lbad_req);
    n_rec  += int'(recov_req);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic c, input logic e);
    sym_valid = 1'b1; sym_data = d; sym_ctrl = c; sym_err = e;
    @(negedge clk);
    sym_valid = 1'b0; sym_ctrl = 1'b0; sym_err = 1'b0; sym_data = '0;
  endtask

  task automatic idle(input int n);
    sym_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // sends one scenario; gap_at >= 0 inserts 2 invalid cycles before that payload index
  task automatic run_vec(input vec_t v, input int gap_at, input string tag);
    int a0, l0, r0, exp_code;
    a0 = n_ack; l0 = n_lbad; r0 = n_rec;
    for (int i = 0; i < 3; i++) put(8'h00, 1'b0, 1'b0);
    for (int p = 0; p < 4; p++) begin
      logic [7:0] d;
      logic c, e;
      d = (p == 3) ? C_END : C_START; c = 1'b1; e = 1'b0;
      if (p == int'(v.fa) || p == int'(v.fb)) begin
        if (v.fk) c = 1'b0; else e = 1'b1;
      end
      put(d, c, e);
      if (p == 3) begin
        // R4: recovery pulse in the cycle after the 4th attempt symbol
        exp_code = (v.ex == 2'd2) ? 1 : 0;
        chk(recov_req == exp_code[0], {tag, " R4 recovery timing"}, int'(recov_req), exp_code);
      end
    end
    for (int i = 0; i < PLEN; i++) begin
      logic [7:0] d;
      logic c, e;
      d = 8'h10 + 8'(i); c = 1'b0; e = 1'b0;
      if (i == int'(v.pi)) begin
        case (v.pk)
          2'd0: begin d = 8'hAA; c = 1'b1; end
          2'd1: e = 1'b1;
          default: begin d = C_END; c = 1'b1; end
        endcase
      end
      if (i == gap_at) idle(2);
      if (i == PLEN-1) crc_ok = v.crc;
      put(d, c, e);
      crc_ok = 1'b1;
      if (i == PLEN-1 && v.ex != 2'd2) begin
        // R7: reply high exactly in the cycle after the last payload symbol
        chk(ack_req == (v.ex == 2'd0) && lbad_req == (v.ex == 2'd1),
            {tag, " R7 reply timing"}, int'({ack_req, lbad_req}),
            (v.ex == 2'd0) ? 2 : 1);
      end
    end
    idle(3);
    exp_code = (v.ex == 2'd0) ? 100 : (v.ex == 2'd1) ? 10 : 1;
    chk((n_ack - a0) * 100 + (n_lbad - l0) * 10 + (n_rec - r0) == exp_code,
        {tag, " R2/R3/R4/R5/R6 pulse counts (ack*100+lbad*10+recov)"},
        (n_ack - a0) * 100 + (n_lbad - l0) * 10 + (n_rec - r0), exp_code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ack_req && !lbad_req && !recov_req, "R1 outputs in reset", int'({ack_req, lbad_req, recov_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sym_ready == 1'b1, "R1 ready after reset", int'(sym_ready), 1);
    chk(!ack_req && !lbad_req && !recov_req, "R1 outputs after reset", int'({ack_req, lbad_req, recov_req}), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], -1, $sformatf("vec%0d", k));

    // R8: rejected packet then its clean retransmission
    run_vec(VECS[8], -1, "R8 reject");
    run_vec(CLEAN, -1, "R8 retransmit");

    // R7: idle gaps inside the payload do not advance the count
    run_vec(CLEAN, 7, "R7 gap mid");
    run_vec(VECS[11], 15, "R7 gap before last");

    // R9: link inactive, whole clean packet ignored
    begin
      int a0, l0, r0;
      a0 = n_ack; l0 = n_lbad; r0 = n_rec;
      link_u0 = 1'b0;
      put(C_START, 1'b1, 1'b1); put(8'h01, 1'b0, 1'b1);
      for (int p = 0; p < 4; p++) put((p == 3) ? C_END : C_START, 1'b1, 1'b0);
      for (int i = 0; i < PLEN; i++) put(8'h20, 1'b0, 1'b0);
      idle(3);
      chk(n_ack == a0 && n_lbad == l0 && n_rec == r0, "R9 ignored while link down",
          (n_ack - a0) + (n_lbad - l0) + (n_rec - r0), 0);
      link_u0 = 1'b1;
      // R9: packet cut by a link drop is discarded
      a0 = n_ack; l0 = n_lbad; r0 = n_rec;
      for (int p = 0; p < 4; p++) put((p == 3) ? C_END : C_START, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) put(8'h30, 1'b0, 1'b0);
      link_u0 = 1'b0;
      idle(2);
      link_u0 = 1'b1;
      idle(1);
      chk(n_ack == a0 && n_lbad == l0 && n_rec == r0, "R9 partial packet dropped",
          (n_ack - a0) + (n_lbad - l0) + (n_rec - r0), 0);
      run_vec(CLEAN, -1, "R9 clean after drop");
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule